// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital control side of a multi-channel analog-to-digital converter peripheral, driven from a simple processor register bus. It keeps a bank of per-slot configuration bytes and a bank of per-slot result words. Software reaches both banks through one data-port register. A pointer in the status register selects the bank and the slot, and the pointer advances after every data-port access. Back-to-back data-port accesses therefore walk through consecutive slots.

When software sets the start bit, the controller converts slot 0, then slot 1, and so on up to a programmable last-slot index. In single-shot mode it stops after the last slot and clears the start bit itself. In continuous mode it wraps back to slot 0 until software clears the start bit. The converter is modelled as a request/done handshake. Each request is launched on a tick of a divided conversion clock. A sample counter raises a sticky data-available interrupt after a programmed number of samples. A separate one-bit register drives the enable of an internal temperature source.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the CTRL (addr 0), STAT (addr 1), LAST (addr 3) and TEMP (addr 4) registers read 0, and `irq` and `cv_req` are low.
- R2: CTRL[1:0] = s makes `cv_clk_en` pulse for one cycle once every 2<<s cycles (s = 2 gives divide by 8). Two pulses are never adjacent.
- R3: STAT[4] selects the bank reached by the DATA port (addr 2): 1 selects configuration, 0 selects results. STAT[2:0] holds the slot. Every DATA read or write advances the slot by one, wrapping from 7 to 0 inside the same bank.
- R4: A DATA write while the pointer selects the result bank leaves the result unchanged, but the pointer still advances.
- R5: Writing STAT[6]=1 with CTRL[6]=0 converts slots 0 through LAST[2:0] once, in order. Hardware then clears STAT[6].
- R6: With CTRL[6]=1 the slot sequence repeats from slot 0 after LAST. Writing STAT[6]=0 lets the in-flight conversion finish and then issues no further request.
- R7: `cv_req` rises only in the cycle after a `cv_clk_en` pulse and stays high until `cv_done`, then drops. While `cv_req` is high, `cv_cfg` carries the configuration byte of the slot being converted.
- R8: On `cv_done`, `cv_result` is stored in the result slot being converted.
- R9: A configuration byte with bit 3 = 1 (differential) and bits [1:0] = 11 is reserved. Its conversion still completes a handshake but stores 0.
- R10: CTRL[11:8] = N sets `irq` and STAT[7] on every (N+1)th completed sample, and the sample count restarts from zero at that point.
- R11: `irq` stays set until a STAT write with bit 7 = 0. A STAT write with bit 7 = 1 leaves it set.
- R12: TEMP bit 0 is read/write and drives `temp_en`. TEMP bits 15:1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (advances the pointer on DATA) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on `bus_addr` |
| cv_clk_en | output | 1 | Divided conversion clock enable |
| cv_req | output | 1 | Conversion request to the converter |
| cv_cfg | output | 8 | Configuration byte of the current slot |
| cv_done | input | 1 | One-cycle conversion completion from the converter |
| cv_result | input | 16 | Conversion result, valid with `cv_done` |
| temp_en | output | 1 | Enable of the internal temperature source |
| irq | output | 1 | Sticky data-available interrupt |

## Verification
The assertions check the handshake shape on every cycle. A request is held until done, drops right after done, and rises only after a conversion-clock tick. They also check that ticks are never adjacent, that the interrupt is sticky and rises only on a completed sample, and that the upper temperature-register bits read zero. The bench scenarios cover what spans many cycles or needs software-visible state:
- the order of configuration bytes presented across a sequence;
- the stored results, including the zero for a reserved code;
- pointer advance and wrap;
- single-shot self-clearing of the start bit;
- the exact divisor;
- the sample count at which the interrupt fires;
- the stop of continuous mode.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // register addresses on the processor bus
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_DATA = 2;
  localparam int ADDR_LAST = 3;
  localparam int ADDR_TEMP = 4;

  // field positions
  localparam int CTRL_DIV_LSB  = 0;
  localparam int CTRL_CONT_BIT = 6;
  localparam int CTRL_PER_LSB  = 8;
  localparam int STAT_BANK_BIT = 4;
  localparam int STAT_GO_BIT   = 6;
  localparam int STAT_IRQ_BIT  = 7;

  // configuration byte layout
  localparam int CFG_W        = 8;
  localparam int CFG_DIFF_BIT = 3;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_CONV = 2'd2
  } seq_state_e;

  // differential with pair code 11 has no input pair behind it
  function automatic logic cfg_reserved(input logic [CFG_W-1:0] c);
    return c[CFG_DIFF_BIT] && (c[1:0] == 2'b11);
  endfunction

endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] sel,
  output logic            tick
);
  localparam int MAXDIV = 2 << ((1 << SELW) - 1);
  localparam int CNTW   = $clog2(MAXDIV);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [CNTW:0]   div_full, term_full;

  always_comb begin
    div_full  = {{(CNTW-1){1'b0}}, 2'b10} << sel;
    term_full = div_full - {{CNTW{1'b0}}, 1'b1};
    // compare with >= so a smaller divisor takes effect at once
    tick      = ({1'b0, cnt_q} >= term_full);
    cnt_d     = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_regbank.sv
module adc_regbank
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int RW    = 16,
  parameter int PW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_we,
  input  logic [PW:0]      ptr_wdata,
  input  logic             dp_we,
  input  logic             dp_re,
  input  logic [CFG_W-1:0] dp_wdata,
  input  logic             res_we,
  input  logic [PW-1:0]    res_idx,
  input  logic [RW-1:0]    res_wdata,
  input  logic [PW-1:0]    seq_idx,
  output logic [PW:0]      ptr_q,
  output logic [RW-1:0]    dp_rdata,
  output logic [CFG_W-1:0] seq_cfg
);
  logic [PW:0]      ptr_d;
  logic [PW-1:0]    ptr_slot;
  logic             ptr_bank;
  logic [CFG_W-1:0] cfg_q [NSLOT];
  logic [RW-1:0]    res_q [NSLOT];

  assign ptr_slot = ptr_q[PW-1:0];
  assign ptr_bank = ptr_q[PW];

  // pointer: explicit write, else advance on any data-port access
  always_comb begin
    ptr_d = ptr_q;
    if (ptr_we) begin
      ptr_d = ptr_wdata;
    end else if (dp_we || dp_re) begin
      ptr_d[PW-1:0] = (ptr_slot == PW'(NSLOT-1)) ? '0 : ptr_slot + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic cfg_en, res_en;
    assign cfg_en = dp_we && ptr_bank && (ptr_slot == PW'(g));
    assign res_en = res_we && (res_idx == PW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q[g] <= '0;
      else if (cfg_en) cfg_q[g] <= dp_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q[g] <= '0;
      else if (res_en) res_q[g] <= res_wdata;
    end
  end

  assign dp_rdata = ptr_bank ? {{(RW-CFG_W){1'b0}}, cfg_q[ptr_slot]} : res_q[ptr_slot];
  assign seq_cfg  = cfg_q[seq_idx];
endmodule

// File: rtl/adc_sequencer.sv
module adc_sequencer
  import adc_seq_pkg::*;
#(
  parameter int PW = 3,
  parameter int RW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             cont,
  input  logic [PW-1:0]    last,
  input  logic             tick,
  input  logic [CFG_W-1:0] cfg,
  input  logic             cv_done,
  input  logic [RW-1:0]    cv_result,
  output logic             cv_req,
  output logic [PW-1:0]    slot,
  output logic             res_we,
  output logic [RW-1:0]    res_wdata,
  output logic             finish
);
  seq_state_e    state_q, state_d;
  logic [PW-1:0] slot_q, slot_d;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    res_we  = 1'b0;
    finish  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (go) begin
          slot_d  = '0;
          state_d = SQ_WAIT;
        end
      end
      SQ_WAIT: begin
        if (!go)       state_d = SQ_IDLE;
        else if (tick) state_d = SQ_CONV;
      end
      SQ_CONV: begin
        if (cv_done) begin
          res_we = 1'b1;
          if (slot_q >= last) begin
            slot_d = '0;
            if (cont && go) begin
              state_d = SQ_WAIT;
            end else begin
              state_d = SQ_IDLE;
              finish  = !cont;
            end
          end else begin
            slot_d  = slot_q + 1'b1;
            state_d = go ? SQ_WAIT : SQ_IDLE;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

  assign cv_req    = (state_q == SQ_CONV);
  assign slot      = slot_q;
  assign res_wdata = cfg_reserved(cfg) ? '0 : cv_result;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int RW    = 16,
  parameter int DW    = 16,
  parameter int AW    = 3,
  parameter int SELW  = 2,
  parameter int IRQW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             cv_clk_en,
  output logic             cv_req,
  output logic [CFG_W-1:0] cv_cfg,
  input  logic             cv_done,
  input  logic [RW-1:0]    cv_result,
  output logic             temp_en,
  output logic             irq
);
  localparam int PW = $clog2(NSLOT);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_ni = rst_sync_q;

  // register decode
  logic wr_ctrl, wr_stat, wr_last, wr_temp, dp_we, dp_re;
  assign wr_ctrl = bus_wr && (bus_addr == AW'(ADDR_CTRL));
  assign wr_stat = bus_wr && (bus_addr == AW'(ADDR_STAT));
  assign wr_last = bus_wr && (bus_addr == AW'(ADDR_LAST));
  assign wr_temp = bus_wr && (bus_addr == AW'(ADDR_TEMP));
  assign dp_we   = bus_wr && (bus_addr == AW'(ADDR_DATA));
  assign dp_re   = bus_rd && (bus_addr == AW'(ADDR_DATA));

  logic [SELW-1:0] div_q, div_d;
  logic            cont_q, cont_d, go_q, go_d, irq_q, irq_d, temp_q, temp_d;
  logic [IRQW-1:0] per_q, per_d, scnt_q, scnt_d;
  logic [PW-1:0]   last_q, last_d;

  logic [PW:0]      ptr_q;
  logic [RW-1:0]    dp_rdata;
  logic [PW-1:0]    seq_slot;
  logic             res_we, finish, irq_set;
  logic [RW-1:0]    res_wdata;

  adc_clkdiv #(.SELW(SELW)) u_div (
    .clk  (clk),
    .rst_n(rst_ni),
    .sel  (div_q),
    .tick (cv_clk_en)
  );

  adc_regbank #(.NSLOT(NSLOT), .RW(RW), .PW(PW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_ni),
    .ptr_we   (wr_stat),
    .ptr_wdata({bus_wdata[STAT_BANK_BIT], bus_wdata[PW-1:0]}),
    .dp_we    (dp_we),
    .dp_re    (dp_re),
    .dp_wdata (bus_wdata[CFG_W-1:0]),
    .res_we   (res_we),
    .res_idx  (seq_slot),
    .res_wdata(res_wdata),
    .seq_idx  (seq_slot),
    .ptr_q    (ptr_q),
    .dp_rdata (dp_rdata),
    .seq_cfg  (cv_cfg)
  );

  adc_sequencer #(.PW(PW), .RW(RW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .go       (go_q),
    .cont     (cont_q),
    .last     (last_q),
    .tick     (cv_clk_en),
    .cfg      (cv_cfg),
    .cv_done  (cv_done),
    .cv_result(cv_result),
    .cv_req   (cv_req),
    .slot     (seq_slot),
    .res_we   (res_we),
    .res_wdata(res_wdata),
    .finish   (finish)
  );

  // next state of the control and status registers
  always_comb begin
    div_d  = div_q;
    cont_d = cont_q;
    per_d  = per_q;
    last_d = last_q;
    temp_d = temp_q;
    go_d   = go_q;
    if (wr_ctrl) begin
      div_d  = bus_wdata[CTRL_DIV_LSB +: SELW];
      cont_d = bus_wdata[CTRL_CONT_BIT];
      per_d  = bus_wdata[CTRL_PER_LSB +: IRQW];
    end
    if (wr_last) last_d = bus_wdata[PW-1:0];
    if (wr_temp) temp_d = bus_wdata[0];
    if (wr_stat)     go_d = bus_wdata[STAT_GO_BIT];
    else if (finish) go_d = 1'b0;

    // sample counter and sticky interrupt
    scnt_d  = scnt_q;
    irq_set = 1'b0;
    if (res_we) begin
      if (scnt_q == per_q) begin
        scnt_d  = '0;
        irq_set = 1'b1;
      end else begin
        scnt_d  = scnt_q + 1'b1;
      end
    end
    irq_d = irq_q;
    if (irq_set)                                   irq_d = 1'b1;
    else if (wr_stat && !bus_wdata[STAT_IRQ_BIT])  irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      cont_q <= 1'b0;
      per_q  <= '0;
      last_q <= '0;
      temp_q <= 1'b0;
      go_q   <= 1'b0;
      scnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      div_q  <= div_d;
      cont_q <= cont_d;
      per_q  <= per_d;
      last_q <= last_d;
      temp_q <= temp_d;
      go_q   <= go_d;
      scnt_q <= scnt_d;
      irq_q  <= irq_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(ADDR_CTRL): begin
        bus_rdata[CTRL_DIV_LSB +: SELW] = div_q;
        bus_rdata[CTRL_CONT_BIT]        = cont_q;
        bus_rdata[CTRL_PER_LSB +: IRQW] = per_q;
      end
      AW'(ADDR_STAT): begin
        bus_rdata[PW-1:0]        = ptr_q[PW-1:0];
        bus_rdata[STAT_BANK_BIT] = ptr_q[PW];
        bus_rdata[STAT_GO_BIT]   = go_q;
        bus_rdata[STAT_IRQ_BIT]  = irq_q;
      end
      AW'(ADDR_DATA): bus_rdata = DW'(dp_rdata);
      AW'(ADDR_LAST): bus_rdata[PW-1:0] = last_q;
      AW'(ADDR_TEMP): bus_rdata[0] = temp_q;
      default:        bus_rdata = '0;
    endcase
  end

  assign temp_en = temp_q;
  assign irq     = irq_q;

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk
  import adc_seq_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          cv_clk_en,
  input logic          cv_req,
  input logic          cv_done,
  input logic          irq
);
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_req && !cv_done) |=> cv_req);

  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_req && cv_done) |=> !cv_req);

  p_req_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_req) |-> $past(cv_clk_en));

  p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cv_clk_en |=> !cv_clk_en);

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_wr && bus_addr == AW'(ADDR_STAT) && !bus_wdata[STAT_IRQ_BIT])) |=> irq);

  p_irq_on_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cv_req && cv_done));

  p_temp_upper_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == AW'(ADDR_TEMP)) |-> (bus_rdata[DW-1:1] == '0));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .cv_clk_en(cv_clk_en),
  .cv_req   (cv_req),
  .cv_done  (cv_done),
  .irq      (irq)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        cv_clk_en, cv_req, cv_done, temp_en, irq;
  logic [7:0]  cv_cfg;
  logic [15:0] cv_result;

  always #2 clk = ~clk;  // 250 MHz

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cv_clk_en(cv_clk_en), .cv_req(cv_req), .cv_cfg(cv_cfg),
    .cv_done(cv_done), .cv_result(cv_result), .temp_en(temp_en), .irq(irq)
  );

  int n_chk = 0, n_bad = 0, done_cnt = 0;
  logic [7:0] exp_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'(a);
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    int v;
    rd(a, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic measure(output int p);
    p = 0;
    do @(negedge clk); while (!cv_clk_en);
    do begin @(negedge clk); p++; end while (!cv_clk_en);
  endtask

  task automatic wait_idle;
    int v;
    for (int i = 0; i < 2000; i++) begin
      rd(1, v);
      if (!v[6]) break;
    end
  endtask

  // converter model: answers each request after a short latency
  initial begin
    int lat;
    lat = 2; cv_done = 1'b0; cv_result = '0;
    forever begin
      @(negedge clk);
      if (cv_done) cv_done = 1'b0;
      else if (cv_req) begin
        if (lat == 0) begin
          cv_done = 1'b1; cv_result = 16'(16'h5000 + done_cnt);
          done_cnt++; lat = 2;
        end else lat--;
      end
    end
  end

  // monitor: each new request must present the next expected config byte (R7)
  initial begin
    logic prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && cv_req && !prev) begin
        if (exp_q.size() == 0) check(1'b0, "R7 unexpected request", int'(cv_cfg), 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(cv_cfg == e, "R7 cfg order", int'(cv_cfg), int'(e));
        end
      end
      prev = cv_req;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, p, base;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_chk(0, 0, "R1 CTRL");
    rd_chk(1, 0, "R1 STAT");
    rd_chk(3, 0, "R1 LAST");
    rd_chk(4, 0, "R1 TEMP");
    check(irq == 1'b0 && cv_req == 1'b0, "R1 irq/req", {irq, cv_req}, 0);

    // R12 temperature enable register
    wr(4, 16'hFFFF);
    rd_chk(4, 1, "R12 TEMP upper bits zero");
    check(temp_en == 1'b1, "R12 temp_en", temp_en, 1);
    wr(4, 0);
    check(temp_en == 1'b0, "R12 temp_en off", temp_en, 0);

    // R2 divisor
    wr(0, 16'h0002);
    measure(p); check(p == 8, "R2 divide by 8", p, 8);
    wr(0, 16'h0000);
    measure(p); check(p == 2, "R2 divide by 2", p, 2);

    // R3 configuration fill through the data port
    wr(1, 16'h0010);
    wr(2, 16'h06); wr(2, 16'h07); wr(2, 16'h0B); wr(2, 16'h09);
    rd_chk(1, 16'h0014, "R3 pointer advanced");
    wr(1, 16'h0010);
    rd_chk(2, 16'h06, "R3 cfg0"); rd_chk(2, 16'h07, "R3 cfg1");
    rd_chk(2, 16'h0B, "R3 cfg2"); rd_chk(2, 16'h09, "R3 cfg3");
    wr(1, 16'h0017); wr(2, 16'h05);
    rd_chk(1, 16'h0010, "R3 pointer wrap");

    // R5 single-shot, one slot, irq every sample
    wr(3, 0); wr(0, 16'h0000);
    exp_q.push_back(8'h06);
    wr(1, 16'h0040);
    wait_idle();
    rd_chk(1, 16'h0080, "R5 start cleared, R10 irq flag");
    check(irq == 1'b1, "R10 irq N=0", irq, 1);
    rd_chk(2, 16'h5000, "R8 result slot0");
    repeat (20) @(negedge clk);
    check(irq == 1'b1, "R11 irq sticky", irq, 1);
    wr(1, 16'h0080);
    check(irq == 1'b1, "R11 write bit7=1 keeps irq", irq, 1);
    wr(1, 16'h0000);
    check(irq == 1'b0, "R11 irq cleared", irq, 0);

    // R5/R8/R9/R10 single-shot over four slots, irq after 4 samples
    wr(3, 3); wr(0, 16'h0300);
    exp_q.push_back(8'h06); exp_q.push_back(8'h07);
    exp_q.push_back(8'h0B); exp_q.push_back(8'h09);
    wr(1, 16'h0040);
    wait_idle();
    check(done_cnt == 5, "R5 four conversions", done_cnt, 5);
    check(irq == 1'b1, "R10 irq after N+1=4", irq, 1);
    wr(1, 16'h0000);
    wr(2, 16'h1234);
    rd_chk(1, 16'h0001, "R4 pointer still advances");
    wr(1, 16'h0000);
    rd_chk(2, 16'h5001, "R4 result unchanged");
    rd_chk(2, 16'h5002, "R8 result slot1");
    rd_chk(2, 16'h0000, "R9 reserved code stores zero");
    rd_chk(2, 16'h5004, "R8 result slot3");

    // R6 continuous over slots 0..1, irq after 6 samples, divide by 4
    wr(3, 1); wr(0, 16'h0541);
    for (int i = 0; i < 20; i++) exp_q.push_back(i[0] ? 8'h07 : 8'h06);
    base = done_cnt;
    wr(1, 16'h0040);
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
    check(done_cnt - base == 6, "R10 irq after 6 samples", done_cnt - base, 6);
    check(done_cnt - base > 2, "R6 sequence repeats", done_cnt - base, 6);
    wr(1, 16'h0000);
    repeat (10) @(negedge clk);
    base = done_cnt;
    repeat (200) @(negedge clk);
    check(done_cnt == base && !cv_req, "R6 stops after clear", done_cnt, base);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule